// File: doc/BRIEF.md
# Fuse Row Reader with Protected Key Region

This block turns a software write of a read address into a single-row fetch from a one-time-programmable fuse array. The address word carries a page and a row. The block captures them, issues one read on a simple registered row-read port, waits a fixed array latency, and loads the returned 32-bit row into a data register. Software can read that register but cannot write it. Each accepted request ends with a one-cycle completion pulse.

A fixed window of rows holds secret key material. A request that lands in that window never reaches the fuse array. The data register is loaded with zero instead and a sticky error flag is set. The completion pulse is raised as for any other request. The block never clears the error flag on its own; software clears it through a clear strobe. While a request is in flight the block reports busy, and any further address write is dropped.

Top module: `fuse_row_reader`

## Requirements
- R1: After reset, rd_data is zero and rd_done, rd_err, busy and fuse_rd_en are all low.
- R2: The row is taken from address bits 12:5 and the page from bits 16:13; bits 4:0 and 31:17 have no effect on the row and page driven to the array.
- R3: For an unprotected row, rd_data takes the array's 32-bit row value at the same edge that raises rd_done, which is FUSE_LAT+1 clock edges after the edge that accepted the address write.
- R4: Page 0, rows 12 to 35 inclusive, is protected: a request there loads zero into rd_data and never raises fuse_rd_en.
- R5: A protected request sets rd_err at its completion edge, and rd_err stays set across later requests until it is cleared.
- R6: Every accepted request, protected or not, produces rd_done high for exactly one cycle.
- R7: busy is high from the cycle after acceptance until the completion edge; an address write seen while busy is high is dropped and produces no second completion.
- R8: err_clr high with busy low clears rd_err at the next edge; when a clear coincides with the completion of a protected request, the error stays set.
- R9: rd_data changes only at an edge that raises rd_done.
- R10: For an unprotected request, fuse_rd_en is high for exactly one cycle, the cycle after acceptance, with the decoded page and row on fuse_rd_page and fuse_rd_row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr_we | input | 1 | Address write strobe; starts a request when idle |
| rd_addr_wdata | input | 32 | Address word: row in 12:5, page in 16:13 |
| err_clr | input | 1 | Clears the sticky error flag |
| fuse_rd_data | input | 32 | Row value from the array, valid FUSE_LAT edges after fuse_rd_en |
| fuse_rd_en | output | 1 | One-cycle row read request to the array |
| fuse_rd_page | output | 4 | Page of the requested row |
| fuse_rd_row | output | 8 | Row within the page |
| rd_data | output | 32 | Read-only data register |
| rd_done | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Sticky error flag for protected reads |
| busy | output | 1 | High while a request is in flight |

## Verification
Two pairs of events can land in the same cycle. One pair is an error clear and the completion of a protected request. The other is a fresh address write and the final wait cycle of the request in flight. The bench provokes both by driving err_clr or rd_addr_we in the cycle just before the completion edge, in directed cases and at random points. It then checks that the error flag survives the clear, that the second write yields no further completion, and that the data register still holds the first request's result.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    // Request sequencer phases
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/fuse_rd_decode.sv
// Splits the address word into page and row and flags the protected window.
module fuse_rd_decode #(
    parameter int ADDR_W    = 32,
    parameter int ROW_LSB   = 5,
    parameter int ROW_W     = 8,
    parameter int PAGE_W    = 4,
    parameter int BLK_PAGE  = 0,
    parameter int BLK_FIRST = 12,
    parameter int BLK_LAST  = 35
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [PAGE_W-1:0] page,
    output logic [ROW_W-1:0]  row,
    output logic              blocked
);
    localparam int PAGE_LSB = ROW_LSB + ROW_W;
    localparam int TOP_LSB  = PAGE_LSB + PAGE_W;

    logic unused_addr_bits;

    always_comb begin
        row     = addr[ROW_LSB +: ROW_W];
        page    = addr[PAGE_LSB +: PAGE_W];
        blocked = (page == PAGE_W'(BLK_PAGE))
               && (row >= ROW_W'(BLK_FIRST))
               && (row <= ROW_W'(BLK_LAST));
        unused_addr_bits = ^{addr[ROW_LSB-1:0], addr[ADDR_W-1:TOP_LSB]};
    end

endmodule

// File: rtl/fuse_rd_seq.sv
// Accept / issue / wait sequencer; capture fires FUSE_LAT edges after issue.
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic issue,
    output logic capture,
    output logic busy
);
    localparam int CNT_W = $clog2(FUSE_LAT + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        accept  = 1'b0;
        capture = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    seq_d.st  = ST_ISSUE;
                    seq_d.cnt = '0;
                end
            end
            ST_ISSUE: begin
                seq_d.st  = ST_WAIT;
                seq_d.cnt = CNT_W'(1);
            end
            ST_WAIT: begin
                if (seq_q.cnt == CNT_W'(FUSE_LAT)) begin
                    capture   = 1'b1;
                    seq_d.st  = ST_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = CNT_W'(seq_q.cnt + 1'b1);
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.cnt = '0;
            end
        endcase
        issue = (seq_q.st == ST_ISSUE);
        busy  = (seq_q.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/fuse_row_reader.sv
// Fuse row reader: one row per address write, protected window reads as zero.
module fuse_row_reader #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int ROW_LSB   = 5,
    parameter int ROW_W     = 8,
    parameter int PAGE_W    = 4,
    parameter int BLK_PAGE  = 0,
    parameter int BLK_FIRST = 12,
    parameter int BLK_LAST  = 35,
    parameter int FUSE_LAT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_addr_we,
    input  logic [ADDR_W-1:0] rd_addr_wdata,
    input  logic              err_clr,
    input  logic [DATA_W-1:0] fuse_rd_data,
    output logic              fuse_rd_en,
    output logic [PAGE_W-1:0] fuse_rd_page,
    output logic [ROW_W-1:0]  fuse_rd_row,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              rd_err,
    output logic              busy
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  row;
        logic              blk;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
    } rd_regs_t;

    rd_regs_t rd_d, rd_q;

    logic [PAGE_W-1:0] dec_page;
    logic [ROW_W-1:0]  dec_row;
    logic              dec_blocked;
    logic              seq_accept;
    logic              seq_issue;
    logic              seq_capture;
    logic              seq_busy;

    fuse_rd_decode #(
        .ADDR_W    (ADDR_W),
        .ROW_LSB   (ROW_LSB),
        .ROW_W     (ROW_W),
        .PAGE_W    (PAGE_W),
        .BLK_PAGE  (BLK_PAGE),
        .BLK_FIRST (BLK_FIRST),
        .BLK_LAST  (BLK_LAST)
    ) i_decode (
        .addr    (rd_addr_wdata),
        .page    (dec_page),
        .row     (dec_row),
        .blocked (dec_blocked)
    );

    fuse_rd_seq #(
        .FUSE_LAT (FUSE_LAT)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_addr_we),
        .accept  (seq_accept),
        .issue   (seq_issue),
        .capture (seq_capture),
        .busy    (seq_busy)
    );

    always_comb begin
        rd_d      = rd_q;
        rd_d.done = seq_capture;
        if (seq_accept) begin
            rd_d.page = dec_page;
            rd_d.row  = dec_row;
            rd_d.blk  = dec_blocked;
        end
        if (seq_capture) begin
            rd_d.data = rd_q.blk ? '0 : fuse_rd_data;
        end
        // a protected completion wins over a clear in the same cycle
        rd_d.err = (rd_q.err && !err_clr) || (seq_capture && rd_q.blk);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign fuse_rd_en   = seq_issue && !rd_q.blk;
    assign fuse_rd_page = rd_q.page;
    assign fuse_rd_row  = rd_q.row;
    assign rd_data      = rd_q.data;
    assign rd_done      = rd_q.done;
    assign rd_err       = rd_q.err;
    assign busy         = seq_busy;

endmodule

// File: rtl/fuse_row_reader_chk.sv
module fuse_row_reader_chk #(
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 8,
    parameter int PAGE_W    = 4,
    parameter int BLK_PAGE  = 0,
    parameter int BLK_FIRST = 12,
    parameter int BLK_LAST  = 35
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_addr_we,
    input logic              err_clr,
    input logic              fuse_rd_en,
    input logic [PAGE_W-1:0] fuse_rd_page,
    input logic [ROW_W-1:0]  fuse_rd_row,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_done,
    input logic              rd_err,
    input logic              busy
);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    a_r7_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> !busy);

    a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_we && !busy) |=> busy);

    a_r9_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_done |-> $stable(rd_data));

    a_r10_en_single: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_rd_en |=> (!fuse_rd_en && busy));

    a_r4_no_fetch_protected: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_rd_en |-> !((fuse_rd_page == PAGE_W'(BLK_PAGE))
                      && (fuse_rd_row >= ROW_W'(BLK_FIRST))
                      && (fuse_rd_row <= ROW_W'(BLK_LAST))));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err && !err_clr) |=> rd_err);

    a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !busy) |=> !rd_err);

endmodule

bind fuse_row_reader fuse_row_reader_chk #(
    .DATA_W    (DATA_W),
    .ROW_W     (ROW_W),
    .PAGE_W    (PAGE_W),
    .BLK_PAGE  (BLK_PAGE),
    .BLK_FIRST (BLK_FIRST),
    .BLK_LAST  (BLK_LAST)
) i_chk (.*);

// File: tb/test_fuse_row_reader.sv
module test_fuse_row_reader;

    localparam int FL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_addr_we = 1'b0;
    logic [31:0] rd_addr_wdata = '0;
    logic        err_clr = 1'b0;
    logic [31:0] fuse_rd_data;
    logic        fuse_rd_en;
    logic [3:0]  fuse_rd_page;
    logic [7:0]  fuse_rd_row;
    logic [31:0] rd_data;
    logic        rd_done;
    logic        rd_err;
    logic        busy;

    int checks = 0;
    int failures = 0;
    int en_count = 0;
    logic [3:0]  en_page = '0;
    logic [7:0]  en_row = '0;
    logic        exp_err = 1'b0;
    logic [31:0] exp_data = '0;
    logic [31:0] pipe [FL];

    always #10 clk = ~clk;

    fuse_row_reader #(.FUSE_LAT(FL)) i_fuse_row_reader (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_addr_we    (rd_addr_we),
        .rd_addr_wdata (rd_addr_wdata),
        .err_clr       (err_clr),
        .fuse_rd_data  (fuse_rd_data),
        .fuse_rd_en    (fuse_rd_en),
        .fuse_rd_page  (fuse_rd_page),
        .fuse_rd_row   (fuse_rd_row),
        .rd_data       (rd_data),
        .rd_done       (rd_done),
        .rd_err        (rd_err),
        .busy          (busy)
    );

    function automatic logic [31:0] fuse_val(input logic [3:0] pg, input logic [7:0] rw);
        return (32'h9E37_79B9 * ({20'd0, pg, rw} + 32'd1)) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic is_protected(input logic [3:0] pg, input logic [7:0] rw);
        return (pg == 4'd0) && (rw >= 8'd12) && (rw <= 8'd35);
    endfunction

    // registered fuse array model, FL stages
    always @(posedge clk) begin
        if (fuse_rd_en) begin
            pipe[0] <= fuse_val(fuse_rd_page, fuse_rd_row);
            en_count <= en_count + 1;
            en_page <= fuse_rd_page;
            en_row <= fuse_rd_row;
        end
        for (int i = 1; i < FL; i++) pipe[i] <= pipe[i-1];
    end
    assign fuse_rd_data = pipe[FL-1];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one request; clr/poke are driven in the cycle just before completion
    task automatic do_read(input logic [31:0] addr, input logic clr, input logic poke);
        logic [3:0] pg;
        logic [7:0] rw;
        logic       blk;
        int         en_before;
        pg = addr[16:13];
        rw = addr[12:5];
        blk = is_protected(pg, rw);
        en_before = en_count;
        @(negedge clk);
        rd_addr_we = 1'b1;
        rd_addr_wdata = addr;
        @(negedge clk);
        rd_addr_we = 1'b0;
        chk("R7 busy after accept", {31'd0, busy}, 32'd1);
        chk("R10 en cycle after accept", {31'd0, fuse_rd_en}, {31'd0, !blk});
        repeat (FL) @(negedge clk);
        chk("R3 no early done", {31'd0, rd_done}, 32'd0);
        chk("R9 data held in flight", rd_data, exp_data);
        rd_addr_we = poke;
        rd_addr_wdata = 32'h0000_2A60;
        err_clr = clr;
        @(negedge clk);
        rd_addr_we = 1'b0;
        err_clr = 1'b0;
        exp_data = blk ? 32'd0 : fuse_val(pg, rw);
        exp_err = (exp_err && !clr) || blk;
        chk("R6 done raised", {31'd0, rd_done}, 32'd1);
        chk(blk ? "R4 protected reads zero" : "R3 row data", rd_data, exp_data);
        chk(clr ? "R8 set wins over clear" : "R5 error flag", {31'd0, rd_err}, {31'd0, exp_err});
        chk("R4 R10 en count", en_count - en_before, blk ? 32'd0 : 32'd1);
        if (!blk) begin
            chk("R2 page decode", {28'd0, en_page}, {28'd0, pg});
            chk("R2 row decode", {24'd0, en_row}, {24'd0, rw});
        end
        @(negedge clk);
        chk("R6 single pulse", {31'd0, rd_done}, 32'd0);
        chk("R7 busy-time write dropped", {31'd0, busy}, 32'd0);
        chk("R9 data held after", rd_data, exp_data);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        exp_err = 1'b0;
        chk("R8 clear", {31'd0, rd_err}, 32'd0);
        chk("R9 data kept on clear", rd_data, exp_data);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'h0000_5EED);
        for (int i = 0; i < FL; i++) pipe[i] = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset data", rd_data, 32'd0);
        chk("R1 reset flags", {28'd0, rd_done, rd_err, busy, fuse_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {29'd0, rd_done, rd_err, busy}, 32'd0);

        // directed: junk in reserved bits, boundaries of the window
        do_read({15'h7FFF, 4'd3, 8'd200, 5'h1F}, 1'b0, 1'b0);
        do_read({15'd0, 4'd0, 8'd11, 5'd0}, 1'b0, 1'b0);
        do_read({15'd0, 4'd0, 8'd12, 5'd0}, 1'b0, 1'b0);
        do_read({15'd0, 4'd0, 8'd36, 5'd0}, 1'b0, 1'b0);
        chk("R5 error persists", {31'd0, rd_err}, 32'd1);
        clear_err();
        do_read({15'd0, 4'd0, 8'd35, 5'h15}, 1'b0, 1'b0);
        do_read({15'd0, 4'd1, 8'd20, 5'd0}, 1'b0, 1'b0);
        // overlaps: clear with protected completion, write in final wait cycle
        do_read({15'd0, 4'd0, 8'd20, 5'd0}, 1'b1, 1'b1);
        clear_err();
        do_read({15'd0, 4'd9, 8'd77, 5'd0}, 1'b0, 1'b1);

        // random mix
        for (int n = 0; n < 40; n++) begin
            logic [31:0] a;
            a = $urandom;
            a[16:13] = ($urandom % 2 == 0) ? 4'd0 : 4'($urandom % 16);
            a[12:5] = ($urandom % 2 == 0) ? 8'($urandom % 48) : 8'($urandom);
            do_read(a, ($urandom % 4) == 0, ($urandom % 3) == 0);
            if (($urandom % 5) == 0) clear_err();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule